// File: doc/BRIEF.md
# SECDED-Protected True Dual-Port Memory

This block is a true dual-port memory with single-error-correct, double-error-detect protection on both ports. Every data word written through either port is extended with Hamming check bits and an overall parity bit before it is stored. Every word read back is checked: single-bit faults are repaired on the way out, and double-bit faults are flagged. Both ports share one clock. Each port has its own encoder, decoder and status outputs.

The path is fully pipelined with a fixed read latency of four clock edges. The encoder takes one stage, the memory takes two and the decoder takes one. Address, write-enable and read-enable bypass the encoder, so they pass through one register stage and reach the memory in the same cycle as the encoded word.

A fault-injection input inverts stored bit 0 of the port A code word. This lets the correction path be tested in a live system. The repair applies only to data leaving the block; the stored word is not rewritten.

Top module: `ecc_dp_ram`

## Requirements
- R1: Read data and its status flags appear at the outputs after the fourth rising clock edge, counting the edge that samples the read-enable. After the third edge the flags are still low.
- R2: A word written without injection reads back unchanged on either port, with the corrected, detected and fatal flags all low.
- R3: A stored code word is laid out as data in bits [DATA_W-1:0], check bits above it, and overall parity in the top bit. When `inj_a` is high in the cycle of a port A write, bit 0 of that stored word (the data LSB) is inverted. A read of that word returns the original data with corrected=1, detected=1 and fatal=0, on either port.
- R4: After an injected write, the stored word stays faulty. Every later read of it reports a correction until a clean write replaces it, and reads after that clean write show no flags.
- R5: The fatal flag is only ever raised together with the detected flag and never together with the corrected flag. A single-bit fault never raises fatal.
- R6: In any cycle that does not present read data, the corrected, detected and fatal flags of that port are low.
- R7: The injection input has no effect on port B writes, and no effect in cycles without a port A write.
- R8: When a port reads and writes the same address in the same cycle, port A returns the newly written data and port B returns the previously stored data.
- R9: When one port writes an address that the other port reads in the same cycle, the reading port returns the previously stored data. A later read returns the new data.
- R10: When both ports write the same address in the same cycle, the port A data is kept.
- R11: The synchronous active-low reset clears read data and all flags to zero but leaves the memory contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset for pipeline and outputs |
| inj_a | input | 1 | Inverts bit 0 of the port A code word being written |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | DATA_W | Port A write data |
| a_we | input | 1 | Port A write enable |
| a_re | input | 1 | Port A read enable |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | DATA_W | Port B write data |
| b_we | input | 1 | Port B write enable |
| b_re | input | 1 | Port B read enable |
| a_rdata | output | DATA_W | Port A read data, corrected where possible |
| a_corr | output | 1 | Port A single-bit fault repaired |
| a_det | output | 1 | Port A fault detected |
| a_fatal | output | 1 | Port A uncorrectable fault |
| b_rdata | output | DATA_W | Port B read data, corrected where possible |
| b_corr | output | 1 | Port B single-bit fault repaired |
| b_det | output | 1 | Port B fault detected |
| b_fatal | output | 1 | Port B uncorrectable fault |

## Verification
The bench uses the default parameters: 8-bit data, which gives a 13-bit code word with four check bits, and a 4-bit address, which gives sixteen entries. These sizes keep every test address directly reachable. Because injection hits the data LSB, the bench can show that a stored 0xFF held as 0xFE is still read out as 0xFF. The sixteen entries let the same-port, mixed-port and contention collisions each use their own address, so no test disturbs the results of another.

// File: rtl/ecc_dp_pkg.sv
// Package: shared Hamming helpers for the SECDED encoder and decoder.
// Assumes data widths of at most 64 bits.
package ecc_dp_pkg;

    // Number of Hamming check bits needed for dw data bits
    function automatic int chk_bits(int dw);
        for (int p = 1; p < 16; p++)
            if ((1 << p) >= dw + p + 1) return p;
        return 16;
    endfunction

    // Hamming position (1-based, skipping powers of two) of data bit k
    function automatic int hpos(int k);
        int cnt;
        cnt = 0;
        for (int p = 1; p < 128; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == k) return p;
                cnt++;
            end
        end
        return 0;
    endfunction

    // Check bit i over the low dw bits of d
    function automatic logic chk_bit(logic [63:0] d, int dw, int i);
        logic acc;
        int   pos;
        acc = 1'b0;
        for (int k = 0; k < 64; k++) begin
            pos = hpos(k);
            if (k < dw && pos[i]) acc = acc ^ d[k];
        end
        return acc;
    endfunction

endpackage

// File: rtl/ecc_enc.sv
// Module: ecc_enc
// One-stage SECDED encoder. Builds {parity, checks, data} and registers it.
// When inj_i is high, bit 0 of the registered word is inverted. The
// injection is sampled on the same edge as the data.
module ecc_enc #(
    parameter int DATA_W = 8,
    localparam int CHK_W = ecc_dp_pkg::chk_bits(DATA_W),
    localparam int CODE_W = DATA_W + CHK_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_i,
    input  logic              inj_i,
    output logic [CODE_W-1:0] code_o
);
    logic [CHK_W-1:0]  chk;
    logic [CODE_W-1:0] word;

    // Check bits from the data
    always_comb begin
        for (int i = 0; i < CHK_W; i++)
            chk[i] = ecc_dp_pkg::chk_bit(64'(data_i), DATA_W, i);
    end

    // Assemble the code word with even overall parity, then apply injection
    always_comb begin
        word    = {^{chk, data_i}, chk, data_i};
        word[0] = word[0] ^ inj_i;
    end

    // Register the encoded word
    always_ff @(posedge clk) begin
        if (!rst_n) code_o <= '0;
        else        code_o <= word;
    end

    // R3
    enc_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inj_i |=> (^code_o) == 1'b0);
endmodule

// File: rtl/ecc_dp_mem.sv
// Module: ecc_dp_mem
// Two-stage true dual-port code-word store. Stage 1 reads the array, stage 2
// registers the output. Port A reads the new word when it writes the same
// address; port B and all cross-port reads see the old word. When both ports
// write the same address, port A wins. The array has no reset.
module ecc_dp_mem #(
    parameter int ADDR_W = 4,
    parameter int CODE_W = 13,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [CODE_W-1:0] a_wd,
    input  logic              a_we,
    input  logic              a_re,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [CODE_W-1:0] b_wd,
    input  logic              b_we,
    input  logic              b_re,
    output logic [CODE_W-1:0] a_rd,
    output logic              a_rv,
    output logic [CODE_W-1:0] b_rd,
    output logic              b_rv
);
    logic [CODE_W-1:0] mem [DEPTH];
    logic [CODE_W-1:0] a_s1, b_s1;
    logic              a_v1, b_v1;

    // Array writes: B first, so A overrides on a shared address
    always_ff @(posedge clk) begin
        if (b_we) mem[b_addr] <= b_wd;
        if (a_we) mem[a_addr] <= a_wd;
    end

    // Stage 1: array read with per-port read-during-write behaviour
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_s1 <= '0; b_s1 <= '0; a_v1 <= 1'b0; b_v1 <= 1'b0;
        end else begin
            a_v1 <= a_re;
            b_v1 <= b_re;
            if (a_re) a_s1 <= a_we ? a_wd : mem[a_addr];
            if (b_re) b_s1 <= mem[b_addr];
        end
    end

    // Stage 2: output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rd <= '0; b_rd <= '0; a_rv <= 1'b0; b_rv <= 1'b0;
        end else begin
            a_rd <= a_s1; b_rd <= b_s1;
            a_rv <= a_v1; b_rv <= b_v1;
        end
    end

    // R1
    mem_lat_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_re |=> ##1 a_rv);
    // R1
    mem_lat_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_re |=> ##1 b_rv);
endmodule

// File: rtl/ecc_dec.sv
// Module: ecc_dec
// One-stage SECDED decoder. Repairs single-bit faults and flags double-bit
// faults. It registers data and flags only when vld_i is high. Flags are
// zero otherwise; data holds its last value.
module ecc_dec #(
    parameter int DATA_W = 8,
    localparam int CHK_W = ecc_dp_pkg::chk_bits(DATA_W),
    localparam int CODE_W = DATA_W + CHK_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] data_o,
    output logic              corr_o,
    output logic              det_o,
    output logic              fatal_o
);
    logic [DATA_W-1:0] d, mask, dfix;
    logic [CHK_W-1:0]  syn;
    logic              odd, pow2, corr, det, fatal;

    // Syndrome, parity and flip mask
    always_comb begin
        d = code_i[DATA_W-1:0];
        for (int i = 0; i < CHK_W; i++)
            syn[i] = code_i[DATA_W+i] ^ ecc_dp_pkg::chk_bit(64'(d), DATA_W, i);
        odd  = ^code_i;
        pow2 = (syn & (syn - 1'b1)) == '0;
        for (int k = 0; k < DATA_W; k++)
            mask[k] = (ecc_dp_pkg::hpos(k) == int'(syn));
    end

    // Classify the fault and form output data
    always_comb begin
        dfix = d; corr = 1'b0; det = 1'b0; fatal = 1'b0;
        if (odd && (pow2 || mask != '0)) begin
            dfix = d ^ mask; corr = 1'b1; det = 1'b1;
        end else if (odd || syn != '0) begin
            det = 1'b1; fatal = 1'b1;
        end
    end

    // Output register, flags only with valid data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0; corr_o <= 1'b0; det_o <= 1'b0; fatal_o <= 1'b0;
        end else begin
            if (vld_i) data_o <= dfix;
            corr_o  <= vld_i & corr;
            det_o   <= vld_i & det;
            fatal_o <= vld_i & fatal;
        end
    end

    // R6
    dec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> !(corr_o || det_o || fatal_o));
    // R5
    dec_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |-> (det_o && !corr_o));
    // R3
    dec_corr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        corr_o |-> det_o);
endmodule

// File: rtl/ecc_dp_ram.sv
// Module: ecc_dp_ram
// Top: SECDED-protected true dual-port memory with a four-cycle read latency.
// Control and address are delayed one stage to line up with the encoders.
// Assumes one shared clock and a synchronous active-low reset.
module ecc_dp_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    localparam int CHK_W = ecc_dp_pkg::chk_bits(DATA_W),
    localparam int CODE_W = DATA_W + CHK_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inj_a,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_we,
    input  logic              a_re,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_we,
    input  logic              b_re,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_corr,
    output logic              a_det,
    output logic              a_fatal,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_corr,
    output logic              b_det,
    output logic              b_fatal
);
    logic [ADDR_W-1:0] a_addr_q, b_addr_q;
    logic              a_we_q, a_re_q, b_we_q, b_re_q;
    logic [CODE_W-1:0] a_code, b_code, a_rcode, b_rcode;
    logic              a_rv, b_rv;

    // Delay address and enables to match the encoder stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_addr_q <= '0; b_addr_q <= '0;
            a_we_q <= 1'b0; a_re_q <= 1'b0; b_we_q <= 1'b0; b_re_q <= 1'b0;
        end else begin
            a_addr_q <= a_addr; b_addr_q <= b_addr;
            a_we_q <= a_we; a_re_q <= a_re; b_we_q <= b_we; b_re_q <= b_re;
        end
    end

    ecc_enc #(.DATA_W(DATA_W)) u_enc_a (
        .clk(clk), .rst_n(rst_n), .data_i(a_wdata), .inj_i(inj_a), .code_o(a_code));
    ecc_enc #(.DATA_W(DATA_W)) u_enc_b (
        .clk(clk), .rst_n(rst_n), .data_i(b_wdata), .inj_i(1'b0), .code_o(b_code));

    ecc_dp_mem #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr_q), .a_wd(a_code), .a_we(a_we_q), .a_re(a_re_q),
        .b_addr(b_addr_q), .b_wd(b_code), .b_we(b_we_q), .b_re(b_re_q),
        .a_rd(a_rcode), .a_rv(a_rv), .b_rd(b_rcode), .b_rv(b_rv));

    ecc_dec #(.DATA_W(DATA_W)) u_dec_a (
        .clk(clk), .rst_n(rst_n), .vld_i(a_rv), .code_i(a_rcode),
        .data_o(a_rdata), .corr_o(a_corr), .det_o(a_det), .fatal_o(a_fatal));
    ecc_dec #(.DATA_W(DATA_W)) u_dec_b (
        .clk(clk), .rst_n(rst_n), .vld_i(b_rv), .code_i(b_rcode),
        .data_o(b_rdata), .corr_o(b_corr), .det_o(b_det), .fatal_o(b_fatal));

    // R7
    inj_b_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (^b_code) == 1'b0);
endmodule

// File: tb/ecc_dp_ram_bench.sv
// Directed bench for ecc_dp_ram: one task per scenario, each checking itself.
module ecc_dp_ram_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inj_a = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic          a_we = 1'b0, a_re = 1'b0, b_we = 1'b0, b_re = 1'b0;
    logic [DW-1:0] a_rdata, b_rdata;
    logic          a_corr, a_det, a_fatal, b_corr, b_det, b_fatal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    ecc_dp_ram #(.DATA_W(DW), .ADDR_W(AW)) u_ecc_dp_ram (
        .clk(clk), .rst_n(rst_n), .inj_a(inj_a),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_re(a_re),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_re(b_re),
        .a_rdata(a_rdata), .a_corr(a_corr), .a_det(a_det), .a_fatal(a_fatal),
        .b_rdata(b_rdata), .b_corr(b_corr), .b_det(b_det), .b_fatal(b_fatal));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of operations at a falling edge, then return to idle
    task automatic op(input bit awe, input bit are, input int aad, input int ad,
                      input bit bwe, input bit bre, input int bad, input int bd,
                      input bit inj);
        a_we = awe; a_re = are; a_addr = AW'(aad); a_wdata = DW'(ad);
        b_we = bwe; b_re = bre; b_addr = AW'(bad); b_wdata = DW'(bd);
        inj_a = inj;
        @(negedge clk);
        a_we = 0; a_re = 0; b_we = 0; b_re = 0; inj_a = 0;
    endtask

    function automatic int fa(); return {a_corr, a_det, a_fatal}; endfunction
    function automatic int fb(); return {b_corr, b_det, b_fatal}; endfunction

    task automatic t_reset_state();
        check("R11 reset a_rdata", a_rdata, 0);
        check("R11 reset flags", fa() | fb(), 0);
    endtask

    task automatic t_clean();
        op(1,0,1,8'h5a, 1,0,2,8'ha5, 0);
        op(0,1,2,0, 0,1,1,0, 0);
        repeat (3) @(negedge clk);
        check("R2 a data", a_rdata, 8'ha5);
        check("R2 b data", b_rdata, 8'h5a);
        check("R2 flags", fa() | fb(), 0);
    endtask

    task automatic t_latency();
        op(1,0,3,8'h11, 0,0,0,0, 1);
        op(0,1,3,0, 0,0,0,0, 0);
        repeat (2) @(negedge clk);
        check("R1 flags not yet", fa(), 0);
        check("R1 data not yet", a_rdata, 8'ha5);
        @(negedge clk);
        check("R1 data on 4th edge", a_rdata, 8'h11);
        check("R1 flags on 4th edge", fa(), 3'b110);
        @(negedge clk);
        check("R6 flags idle", fa(), 0);
    endtask

    task automatic t_inject();
        op(1,0,0,8'hff, 0,0,0,0, 1);
        op(0,1,0,0, 0,1,0,0, 0);
        repeat (3) @(negedge clk);
        check("R3 a corrected data", a_rdata, 8'hff);
        check("R3 a flags", fa(), 3'b110);
        check("R3 b corrected data", b_rdata, 8'hff);
        check("R5 b flags no fatal", fb(), 3'b110);
        op(0,1,0,0, 0,1,0,0, 0);
        repeat (3) @(negedge clk);
        check("R4 still faulty a", fa(), 3'b110);
        check("R4 still faulty b", fb(), 3'b110);
        op(1,0,0,8'hff, 0,0,0,0, 0);
        op(0,1,0,0, 0,1,0,0, 0);
        repeat (3) @(negedge clk);
        check("R4 clean after rewrite", fa() | fb(), 0);
        check("R4 data after rewrite", a_rdata, 8'hff);
    endtask

    task automatic t_inj_scope();
        op(0,0,0,0, 1,0,5,8'h3c, 1);
        op(1,0,6,8'h77, 0,0,0,0, 0);
        op(0,1,5,0, 0,1,6,0, 0);
        repeat (3) @(negedge clk);
        check("R7 b write unaffected", a_rdata, 8'h3c);
        check("R7 a write unaffected", b_rdata, 8'h77);
        check("R7 flags", fa() | fb(), 0);
    endtask

    task automatic t_rdw();
        op(1,0,7,8'h10, 1,0,8,8'h20, 0);
        op(1,1,7,8'haa, 1,1,8,8'hbb, 0);
        repeat (3) @(negedge clk);
        check("R8 a new data", a_rdata, 8'haa);
        check("R8 b old data", b_rdata, 8'h20);
        op(0,0,0,0, 0,1,8,0, 0);
        repeat (3) @(negedge clk);
        check("R8 b reread", b_rdata, 8'hbb);
    endtask

    task automatic t_mixed();
        op(1,0,9,8'h31, 0,0,0,0, 0);
        op(1,0,9,8'hcc, 0,1,9,0, 0);
        repeat (3) @(negedge clk);
        check("R9 b sees old", b_rdata, 8'h31);
        op(0,0,0,0, 0,1,9,0, 0);
        repeat (3) @(negedge clk);
        check("R9 b sees new", b_rdata, 8'hcc);
    endtask

    task automatic t_contention();
        op(1,0,10,8'hdd, 1,0,10,8'hee, 0);
        op(0,1,10,0, 0,1,10,0, 0);
        repeat (3) @(negedge clk);
        check("R10 a keeps A", a_rdata, 8'hdd);
        check("R10 b keeps A", b_rdata, 8'hdd);
    endtask

    task automatic t_midreset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        check("R11 data cleared", a_rdata | b_rdata, 0);
        check("R11 flags cleared", fa() | fb(), 0);
        rst_n = 1;
        op(0,1,10,0, 0,1,9,0, 0);
        repeat (3) @(negedge clk);
        check("R11 mem kept a", a_rdata, 8'hdd);
        check("R11 mem kept b", b_rdata, 8'hcc);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset_state();
        rst_n = 1;
        @(negedge clk);
        t_clean();
        t_latency();
        t_inject();
        t_inj_scope();
        t_rdw();
        t_mixed();
        t_contention();
        t_midreset();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule